// File: doc/BRIEF.md
# Packed-Pixel 3x3 Window Filter

This block turns one 3x3 window of unsigned 8-bit pixels into one filtered output pixel. The nine pixels arrive in three 32-bit words, four pixels to a word, on a cycle where `inValid` is high. A 2-bit mode picks the filter. Mode 0 is a box average that divides by eight instead of nine. Mode 1 is a gradient magnitude built from horizontal and vertical differences. Mode 2 is a Laplacian-style edge response. Mode 3 gives zero.

The window and the mode are captured on the valid cycle. The filter is then computed with adders, subtractors and fixed shifts only. The result is saturated into the pixel range and registered. Frame storage, line buffers and border handling belong to the surrounding logic. The block holds one window at a time and accepts a new one on every cycle.

Top module: `pixel_window_filter`

## Requirements
- R1: While `rstN` is low, `outValid` and `outPixel` are both 0.
- R2: `outValid` is high exactly two rising edges after an edge that samples `inValid` high, for one cycle per accepted window. It is low at every other time.
- R3: Pixel z1..z9 is numbered row by row across the window. Pixel z(4k+j+1) is taken from byte j (bits 8j+7:8j) of word k, where word0 is k=0. Bits 31:8 of `word2` have no effect on the result.
- R4: Mode 0 outputs floor((z1+...+z9)/8). A result above 255 becomes 255.
- R5: Mode 1 outputs |gx|+|gy|, clamped to 255. Here gx=(z7+2z8+z9)-(z1+2z2+z3) and gy=(z3+2z6+z9)-(z1+2z4+z7).
- R6: Mode 2 outputs 4z5-(z2+z4+z6+z8). A negative result becomes 0 and a result above 255 becomes 255.
- R7: Mode 3 outputs 0 whatever the pixels are.
- R8: While no new result is presented, `outPixel` keeps its last value.
- R9: The words and the mode are used only on the cycle `inValid` is high. Changing them on later cycles does not alter the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A window and a mode are present this cycle |
| mode | input | 2 | Filter select: 0 box, 1 gradient, 2 Laplacian, 3 zero |
| word0 | input | 32 | Pixels z1..z4, with z1 in the low byte |
| word1 | input | 32 | Pixels z5..z8, with z5 in the low byte |
| word2 | input | 32 | Pixel z9 in the low byte; the upper bytes are ignored |
| outValid | output | 1 | `outPixel` carries a new result |
| outPixel | output | 8 | Saturated filter output |

## Verification
The tests include uniform windows: all zero, and all 255. All 255 pushes the box sum past the clamp and drives both the gradient and the Laplacian to exactly zero. Single hot pixels at z5, z8 and z2 pull the filters apart. A hot z5 saturates the Laplacian. A hot z2 drives the Laplacian negative, so it tests the floor clamp. A step edge between rows saturates the gradient, while small values leave it unclamped, which exposes a wrong tap weight or a wrong shift. Random windows follow, sent back to back and with gaps. They carry garbage in the spare bytes of `word2`, and the inputs are scrambled on idle cycles. These cases show whether unpacking, sampling and output hold are correct in all four modes.

// File: rtl/wf_pkg.sv
package wf_pkg;
  typedef enum logic [1:0] {
    MODE_BOX  = 2'd0,
    MODE_GRAD = 2'd1,
    MODE_LAPL = 2'd2,
    MODE_OFF  = 2'd3
  } filt_mode_e;

  typedef struct packed {
    logic capture;
    logic emit;
  } wf_strobe_t;

  localparam int TAPS = 9;
endpackage

// File: rtl/wf_ctrl.sv
module wf_ctrl
  import wf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output wf_strobe_t strobe,
  output logic       outValid
);
  logic emitQ;
  logic validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emitQ  <= 1'b0;
      validQ <= 1'b0;
    end else begin
      emitQ  <= inValid;
      validQ <= emitQ;
    end
  end

  assign strobe.capture = inValid;
  assign strobe.emit    = emitQ;
  assign outValid       = validQ;
endmodule

// File: rtl/wf_kernel.sv
module wf_kernel
  import wf_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic [TAPS*PIX_W-1:0] pix,
  input  filt_mode_e            mode,
  output logic [PIX_W-1:0]      result
);
  localparam int ACC_W = PIX_W + 5;
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] p [TAPS];

  for (genvar t = 0; t < TAPS; t++) begin : g_widen
    assign p[t] = {{(ACC_W-PIX_W){1'b0}}, pix[t*PIX_W +: PIX_W]};
  end

  logic signed [ACC_W-1:0] boxSum, boxDiv, gx, gy, absX, absY, gradMag, lapl;

  function automatic logic [PIX_W-1:0] clampPix(input logic signed [ACC_W-1:0] v);
    if (v < 0)            return '0;
    else if (v > PIX_MAX) return PIX_MAX[PIX_W-1:0];
    else                  return v[PIX_W-1:0];
  endfunction

  always_comb begin
    boxSum  = p[0] + p[1] + p[2] + p[3] + p[4] + p[5] + p[6] + p[7] + p[8];
    boxDiv  = boxSum >>> 3;
    gx      = (p[6] + (p[7] <<< 1) + p[8]) - (p[0] + (p[1] <<< 1) + p[2]);
    gy      = (p[2] + (p[5] <<< 1) + p[8]) - (p[0] + (p[3] <<< 1) + p[6]);
    absX    = (gx < 0) ? -gx : gx;
    absY    = (gy < 0) ? -gy : gy;
    gradMag = absX + absY;
    lapl    = (p[4] <<< 2) - (p[1] + p[3] + p[5] + p[7]);
    unique case (mode)
      MODE_BOX:  result = clampPix(boxDiv);
      MODE_GRAD: result = clampPix(gradMag);
      MODE_LAPL: result = clampPix(lapl);
      default:   result = '0;
    endcase
  end
endmodule

// File: rtl/wf_datapath.sv
module wf_datapath
  import wf_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wf_strobe_t            strobe,
  input  logic [TAPS*PIX_W-1:0] winIn,
  input  logic [1:0]            modeIn,
  output logic [PIX_W-1:0]      outPixel
);
  logic [TAPS*PIX_W-1:0] winQ;
  filt_mode_e            modeQ;
  logic [PIX_W-1:0]      kernelOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winQ  <= '0;
      modeQ <= MODE_OFF;
    end else if (strobe.capture) begin
      winQ  <= winIn;
      modeQ <= filt_mode_e'(modeIn);
    end
  end

  wf_kernel #(.PIX_W(PIX_W)) u_kernel (
    .pix    (winQ),
    .mode   (modeQ),
    .result (kernelOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN)            outPixel <= '0;
    else if (strobe.emit) outPixel <= kernelOut;
  end
endmodule

// File: rtl/pixel_window_filter.sv
module pixel_window_filter
  import wf_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] word0,
  input  logic [WORD_W-1:0] word1,
  input  logic [WORD_W-1:0] word2,
  output logic              outValid,
  output logic [PIX_W-1:0]  outPixel
);
  localparam int BUS_W   = 3 * WORD_W;
  localparam int WIN_W   = TAPS * PIX_W;
  localparam int SPARE_W = BUS_W - WIN_W;

  logic [BUS_W-1:0] bus;
  wf_strobe_t       strobe;

  assign bus = {word2, word1, word0};

  if (SPARE_W > 0) begin : g_spare
    logic unusedSpare;
    assign unusedSpare = ^bus[BUS_W-1:WIN_W];
  end

  wf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  wf_datapath #(.PIX_W(PIX_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .winIn    (bus[WIN_W-1:0]),
    .modeIn   (mode),
    .outPixel (outPixel)
  );
endmodule

// File: rtl/wf_checker.sv
module wf_checker #(
  parameter int PIX_W  = 8,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        mode,
  input logic [WORD_W-1:0] word1,
  input logic              outValid,
  input logic [PIX_W-1:0]  outPixel
);
  // R2
  latency_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outPixel));

  // R7
  off_mode_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(mode, 2) == 2'd3) |-> outPixel == '0);

  // R6
  lapl_dark_centre_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(mode, 2) == 2'd2 && $past(word1[PIX_W-1:0], 2) == '0)
      |-> outPixel == '0);
endmodule

bind pixel_window_filter wf_checker #(.PIX_W(PIX_W), .WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .mode     (mode),
  .word1    (word1),
  .outValid (outValid),
  .outPixel (outPixel)
);

// File: tb/pixel_window_filter_bench.sv
`timescale 1ns/1ps
module pixel_window_filter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [31:0] word0 = '0, word1 = '0, word2 = '0;
  logic        outValid;
  logic [7:0]  outPixel;

  int checks = 0;
  int errors = 0;
  bit armed = 1'b0;

  always #5 clk = ~clk;

  pixel_window_filter u_pixel_window_filter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .word0(word0), .word1(word1), .word2(word2),
    .outValid(outValid), .outPixel(outPixel)
  );

  function automatic int clampRef(int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  function automatic int absI(int v);
    return (v < 0) ? -v : v;
  endfunction

  // R3: z(4k+j+1) lives in byte j of word k; spare bytes of word2 unused
  function automatic int refPix(int md, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    int z[10];
    int gx, gy;
    for (int j = 0; j < 4; j++) begin
      z[1+j] = int'(a[8*j +: 8]);
      z[5+j] = int'(b[8*j +: 8]);
    end
    z[9] = int'(c[7:0]);
    z[0] = 0;
    gx = (z[7] + 2*z[8] + z[9]) - (z[1] + 2*z[2] + z[3]);
    gy = (z[3] + 2*z[6] + z[9]) - (z[1] + 2*z[4] + z[7]);
    case (md)
      0: return clampRef((z[1]+z[2]+z[3]+z[4]+z[5]+z[6]+z[7]+z[8]+z[9]) / 8);
      1: return clampRef(absI(gx) + absI(gy));
      2: return clampRef(4*z[5] - (z[2]+z[4]+z[6]+z[8]));
      default: return 0;
    endcase
  endfunction

  function automatic string tagOf(int md);
    case (md)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // behavioural reference, advanced on each rising edge
  bit    m1V = 0, m2V = 0;
  int    m1P = 0, mOut = 0;
  string m1Tag = "R2", mTag = "R8";

  always @(posedge clk) begin
    if (!rstN) begin
      m1V = 0; m2V = 0; mOut = 0;
    end else begin
      m2V = m1V;
      if (m1V) begin mOut = m1P; mTag = m1Tag; end
      else mTag = "R8";
      m1V = inValid;
      if (inValid) begin
        m1P = refPix(int'(mode), word0, word1, word2);
        m1Tag = tagOf(int'(mode));
      end
    end
  end

  task automatic compareNow();
    checks++;
    if (outValid !== m2V) begin
      errors++;
      $display("FAIL R2 outValid actual %0b expected %0b at %0t", outValid, m2V, $time);
    end
    checks++;
    if (int'(outPixel) !== mOut) begin
      errors++;
      $display("FAIL %s outPixel actual %0d expected %0d at %0t", mTag, outPixel, mOut, $time);
    end
  endtask

  // R9: off-valid cycles carry scrambled words and mode
  task automatic step(bit v, int md, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    @(negedge clk);
    if (armed) compareNow();
    inValid = v;
    mode    = v ? md[1:0] : 2'($urandom);
    word0   = v ? a : $urandom;
    word1   = v ? b : $urandom;
    word2   = v ? c : $urandom;
  endtask

  task automatic allModes(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    for (int md = 0; md < 4; md++) step(1'b1, md, a, b, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (outValid !== 1'b0 || outPixel !== 8'd0) begin
      errors++;
      $display("FAIL R1 reset actual %0b/%0d expected 0/0", outValid, outPixel);
    end
    @(negedge clk);
    rstN = 1'b1;
    armed = 1'b1;

    allModes(32'h0, 32'h0, 32'h0);                       // zero window
    allModes(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_00FF); // R4 clamp, flat
    allModes(32'h0, 32'h0000_00FF, 32'h0);              // hot z5: R6 clamp high
    allModes(32'h0, 32'h0000_00FF, 32'hABCD_EF00);      // R3 spare bytes ignored
    allModes(32'h0000_3200, 32'h0, 32'h0);              // hot z2: R6 negative clamp
    allModes(32'h0000_0300, 32'h0000_000A, 32'h0);      // R6 unclamped 37
    allModes(32'h0, 32'h0A00_0000, 32'h0);              // z8=10: R5 unclamped 20
    allModes(32'h0, 32'hFFFF_0000, 32'h0000_00FF);      // R5 step edge saturates
    allModes(32'h0403_0201, 32'h0807_0605, 32'h5555_5509); // R3 ordering
    repeat (3) step(1'b0, 0, 0, 0, 0);                  // R8 hold
    for (int i = 0; i < 400; i++) begin
      bit v = ($urandom % 3) != 0;
      step(v, int'($urandom % 4), $urandom, $urandom, $urandom);
    end
    repeat (4) step(1'b0, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule